// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable 15-bit ratio and emits one pulse per completed division cycle. The ratio is split into an 11-bit main count M, the upper bits, and a 4-bit swallow count A, the lower bits. A dual-modulus prescaler runs at divide-by-17 for the first A prescaler cycles of each division cycle and at divide-by-16 for the remaining M−A. A full division cycle therefore lasts 16·M + A input clocks.

The output pulse goes to a downstream phase comparator. A divide-by-two copy of that pulse stream, made by toggling a flop on every pulse, can be sent to a test pin while the test enable is high. A new ratio word is written into a holding register with a load strobe. It takes effect only at the next division-cycle boundary, so no output period is ever cut short. A word whose swallow count is larger than its main count, or whose main count is zero, cannot be built from 16/17 cycles. Such a word is rejected and flagged, and the previous ratio stays in use.

Top module: `pswallow_divider`

## Requirements
- R1: The ratio word splits into M = `ratio_word[14:4]` and A = `ratio_word[3:0]`, and `div_pulse` is high once every 16·M + A input clocks.
- R2: Within each division cycle the prescaler counts 17 clocks per prescaler cycle for the first A prescaler cycles and 16 clocks for each later one, M prescaler cycles in all.
- R3: `div_pulse` is exactly one input clock wide.
- R4: `test_out` equals a flop that toggles on every `div_pulse` while `test_en` is 1, and is 0 while `test_en` is 0.
- R5: A word loaded with `ratio_load` = 1 is invalid when A > M or M = 0. An invalid word sets `ratio_err` to 1 on the next clock and leaves the ratio in use unchanged.
- R6: A valid load clears `ratio_err` and is first used for the division cycle that starts at the next boundary. A load on the same clock edge as a boundary is used from the boundary after that.
- R7: While `rst` is high, `div_pulse`, `test_out` and `ratio_err` are 0 and the ratio is set to M = 4, A = 0. The first pulse comes 64 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_word | input | 15 | Ratio: M in bits 14:4, A in bits 3:0 |
| ratio_load | input | 1 | Strobe that captures `ratio_word` |
| test_en | input | 1 | Routes the halved pulse stream to `test_out` |
| div_pulse | output | 1 | One-clock pulse per division cycle |
| test_out | output | 1 | Divide-by-two of the pulse stream, gated by `test_en` |
| ratio_err | output | 1 | Last loaded word was invalid |

## Verification
The assertions check on every clock that the prescaler count stays within 17 states and wraps only at the modulus chosen for it. They also check that the swallow count never exceeds the remaining main count, that pulses are one clock wide, that the test flop changes exactly when a pulse occurs, and that a rejected load leaves the holding register unchanged. Only the bench's reference model can show that the period equals 16·M + A for a range of ratios. The same model shows that a new ratio starts exactly one boundary late, including a load that lands on the boundary edge, and that an error flag set by a bad word is cleared by the next good one.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
    localparam int SW_W   = 4;
    localparam int MAIN_W = 11;
    localparam int PRE_LO = 1 << SW_W;
    localparam int PRE_W  = SW_W + 1;
    localparam int WORD_W = MAIN_W + SW_W;

    typedef struct packed {
        logic [MAIN_W-1:0] m;
        logic [SW_W-1:0]   a;
    } ratio_t;

    function automatic logic ratio_ok(input ratio_t r);
        return (r.m != '0) && (MAIN_W'(r.a) <= r.m);
    endfunction
endpackage

// File: rtl/pswallow_ratio_hold.sv
module pswallow_ratio_hold
    import pswallow_pkg::*;
#(
    parameter ratio_t RST_RATIO = '{m: 11'd4, a: 4'd0}
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  ratio_t word,
    output ratio_t held,
    output logic   err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= RST_RATIO;
            err  <= 1'b0;
        end else if (load) begin
            if (ratio_ok(word)) begin
                held <= word;
                err  <= 1'b0;
            end else begin
                err  <= 1'b1;
            end
        end
    end

    assert_reject_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (load && !ratio_ok(word)) |=> (err && $stable(held)));
    assert_accept_R6: assert property (@(posedge clk) disable iff (rst)
        (load && ratio_ok(word)) |=> (!err && held == $past(word)));
endmodule

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler
    import pswallow_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic use17,
    output logic done
);
    logic [PRE_W-1:0] cnt;

    assign done = (cnt == (use17 ? PRE_W'(PRE_LO) : PRE_W'(PRE_LO - 1)));

    always_ff @(posedge clk) begin
        if (rst || done) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assert_pre_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= PRE_W'(PRE_LO));
    assert_pre_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt == PRE_W'(PRE_LO - 1) && !use17) |=> (cnt == '0));
endmodule

// File: rtl/pswallow_counters.sv
module pswallow_counters
    import pswallow_pkg::*;
#(
    parameter ratio_t RST_RATIO = '{m: 11'd4, a: 4'd0}
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pre_done,
    input  ratio_t next_ratio,
    output logic   use17,
    output logic   terminal
);
    logic [MAIN_W-1:0] m_rem;
    logic [SW_W-1:0]   a_rem;

    assign use17    = (a_rem != '0);
    assign terminal = pre_done && (m_rem == MAIN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            m_rem <= RST_RATIO.m;
            a_rem <= RST_RATIO.a;
        end else if (terminal) begin
            m_rem <= next_ratio.m;
            a_rem <= next_ratio.a;
        end else if (pre_done) begin
            m_rem <= m_rem - 1'b1;
            if (a_rem != '0) a_rem <= a_rem - 1'b1;
        end
    end

    assert_count_order_R2: assert property (@(posedge clk) disable iff (rst)
        (m_rem != '0) && (MAIN_W'(a_rem) <= m_rem));
    assert_main_step_R1: assert property (@(posedge clk) disable iff (rst)
        (pre_done && !terminal) |=> (m_rem == $past(m_rem) - 1'b1));
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
    import pswallow_pkg::*;
#(
    parameter int RST_M = 4,
    parameter int RST_A = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] ratio_word,
    input  logic              ratio_load,
    input  logic              test_en,
    output logic              div_pulse,
    output logic              test_out,
    output logic              ratio_err
);
    localparam ratio_t RST_RATIO = '{m: MAIN_W'(RST_M), a: SW_W'(RST_A)};

    ratio_t held;
    logic   use17, pre_done, terminal, half_q;

    pswallow_ratio_hold #(.RST_RATIO(RST_RATIO)) u_hold (
        .clk(clk), .rst(rst), .load(ratio_load), .word(ratio_t'(ratio_word)),
        .held(held), .err(ratio_err)
    );

    pswallow_prescaler u_pre (
        .clk(clk), .rst(rst), .use17(use17), .done(pre_done)
    );

    pswallow_counters #(.RST_RATIO(RST_RATIO)) u_cnt (
        .clk(clk), .rst(rst), .pre_done(pre_done), .next_ratio(held),
        .use17(use17), .terminal(terminal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_pulse <= 1'b0;
            half_q    <= 1'b0;
        end else begin
            div_pulse <= terminal;
            if (terminal) half_q <= ~half_q;
        end
    end

    assign test_out = test_en & half_q;

    assert_single_width_R3: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);
    assert_half_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        (half_q != $past(half_q)) == div_pulse);
    assert_test_gate_R4: assert property (@(posedge clk) disable iff (rst)
        !test_en |-> !test_out);
endmodule

// File: tb/test_pswallow_divider.sv
module test_pswallow_divider;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] ratio_word = '0;
    logic        ratio_load = 1'b0;
    logic        test_en = 1'b0;
    logic        div_pulse, test_out, ratio_err;

    int total = 0;
    int bad = 0;

    // reference model state
    int cnt, cur_n, pend_n, last_n, cyc;
    bit m_pulse, m_tog, m_err, seen_pulse;

    always #5 clk = ~clk;

    pswallow_divider i_pswallow_divider (
        .clk(clk), .rst(rst), .ratio_word(ratio_word), .ratio_load(ratio_load),
        .test_en(test_en), .div_pulse(div_pulse), .test_out(test_out),
        .ratio_err(ratio_err)
    );

    function automatic int word_n(input logic [14:0] w);
        return 16 * int'(w[14:4]) + int'(w[3:0]);
    endfunction

    function automatic bit word_ok(input logic [14:0] w);
        return (w[14:4] != 0) && (int'(w[3:0]) <= int'(w[14:4]));
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, updated at each rising edge from stable inputs
    always @(posedge clk) begin
        if (rst) begin
            cnt = 0; cur_n = 64; pend_n = 64; last_n = 64;
            m_pulse = 0; m_tog = 0; m_err = 0;
        end else begin
            if (cnt == cur_n - 1) begin
                cnt = 0; last_n = cur_n; cur_n = pend_n;
                m_pulse = 1; m_tog = ~m_tog;
            end else begin
                cnt++; m_pulse = 0;
            end
            if (ratio_load) begin
                if (word_ok(ratio_word)) begin
                    pend_n = word_n(ratio_word); m_err = 0;
                end else m_err = 1;
            end
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; seen_pulse = 0;
        end else begin
            check(div_pulse == m_pulse, "R1 R6 div_pulse", int'(div_pulse), int'(m_pulse));
            check(test_out == (test_en & m_tog), "R4 test_out", int'(test_out), int'(test_en & m_tog));
            check(ratio_err == m_err, "R5 ratio_err", int'(ratio_err), int'(m_err));
            if (div_pulse) begin
                check(cyc == last_n, "R2 period", cyc, last_n);
                seen_pulse = 1;
                cyc = 0;
            end
            cyc++;
        end
    end

    task automatic load(input logic [14:0] w);
        @(posedge clk); #2;
        ratio_word = w; ratio_load = 1'b1;
        @(posedge clk); #2;
        ratio_load = 1'b0;
    endtask

    task automatic wait_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!div_pulse) @(negedge clk);
        end
    endtask

    function automatic logic [14:0] mk(input int m, input int a);
        return {11'(m), 4'(a)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R7: reset state
        check(div_pulse == 0, "R7 reset pulse", int'(div_pulse), 0);
        check(test_out == 0, "R7 reset test_out", int'(test_out), 0);
        check(ratio_err == 0, "R7 reset err", int'(ratio_err), 0);
        @(posedge clk); #2;
        rst = 1'b0;
        test_en = 1'b1;
        wait_pulses(2);                 // R7: first period 64
        check(seen_pulse, "R7 first pulse", int'(seen_pulse), 1);

        // R1 R2: extremes of the swallow count
        load(mk(1, 0));  wait_pulses(3);
        load(mk(15, 15)); wait_pulses(3);
        load(mk(3, 3));  wait_pulses(2);

        // R5: invalid words leave ratio in use
        load(mk(3, 9));  wait_pulses(2);
        check(ratio_err == 1, "R5 A>M flag", int'(ratio_err), 1);
        load(mk(0, 0));  wait_pulses(2);
        check(ratio_err == 1, "R5 M=0 flag", int'(ratio_err), 1);
        load(mk(5, 2));  wait_pulses(2);
        check(ratio_err == 0, "R6 clear flag", int'(ratio_err), 0);

        // R4: test gating off and on
        test_en = 1'b0; wait_pulses(2);
        test_en = 1'b1; wait_pulses(1);

        // R6: load landing on the boundary edge
        @(posedge clk); #2;
        while (cnt != cur_n - 1) begin @(posedge clk); #2; end
        ratio_word = mk(2, 1); ratio_load = 1'b1;
        @(posedge clk); #2;
        ratio_load = 1'b0;
        wait_pulses(3);

        // R6: load mid-cycle, then a second one before the boundary
        load(mk(7, 4)); load(mk(9, 6)); wait_pulses(3);

        // R1: random valid ratios
        for (int k = 0; k < 20; k++) begin
            int m = 1 + int'($urandom_range(40));
            int a = int'($urandom_range((m < 15) ? m : 15));
            load(mk(m, a));
            wait_pulses(2);
        end

        // R1: largest ratio
        load(mk(2047, 15)); wait_pulses(2);
        load(mk(1, 1));     wait_pulses(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule